// File: doc/BRIEF.md
# USB Bridge Upload Controller

This block is the main sequencer between an on-chip capture buffer and an external USB bridge whose endpoint FIFO is written from the chip side. After reset it brings the bridge pins to their idle levels and then waits for a start command. The start command arrives as a byte with a valid strobe, taken from a register area that the host can write. When the start code is seen, the block sends a one-cycle start pulse to the capture buffer. It then waits until the bridge reports its FIFO empty and begins uploading.

During upload it pops bytes from the buffer and puts each one on the bridge data bus. It then pulses an active-low write strobe, but only when the bridge is not signalling full. An acquisition has two endings, and both return the block to command wait. The first is the host stopping its reads, which shows up as a full flag that stays high for a programmable number of cycles; the default is 72,000 cycles, about 1 ms at a 72 MHz clock. The second is an overflow report from the buffer, which also sets a sticky status flag that the host can read.

Top module: `upl_ctrl`

## Requirements
- R1: While reset is held, `fifo_wr_n` is 1, `fifo_addr` is 2'b00, `fifo_data` is 0, and `cap_start`, `buf_rd` and `ovf_flag` are 0. One cycle after reset is released, `fifo_addr` becomes 2'b10 and keeps that value, including during every write strobe.
- R2: Only while waiting for a command, a cycle with `cmd_valid`=1 and `cmd_byte`=8'h0a produces exactly one cycle of `cap_start`=1 on the following cycle. Any other byte value, the start code without `cmd_valid`, or any command given during an acquisition produces no pulse.
- R3: After `cap_start`, no byte is popped and no strobe is issued until `fifo_empty` is sampled as 1.
- R4: `fifo_wr_n` goes low for exactly one cycle per byte. It goes low only in a cycle whose preceding clock edge sampled `fifo_full`=0.
- R5: `fifo_data` keeps the same value in the cycle before a strobe and in the strobe cycle. The bytes written are the popped bytes, one pop per byte, in pop order.
- R6: With `fifo_full`=0 and `buf_valid`=1 held steady during upload, one byte is written every two cycles.
- R7: If `fifo_full` is sampled as 1 on `TIMEOUT_CYC` consecutive edges during upload, the block returns to command wait: no further pops or strobes occur, and a new start code is accepted. A run of `TIMEOUT_CYC`-1 edges does not end the upload.
- R8: `buf_overflow`=1 during upload ends the upload and sets `ovf_flag` from the next cycle on. The flag stays set until the next accepted start command clears it. Outside upload, `buf_overflow` is ignored.
- R9: The full-flag timer restarts on any edge that samples `fifo_full`=0. Two runs of `TIMEOUT_CYC`-1 full edges separated by one clear edge do not end the upload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte is present this cycle |
| cmd_byte | input | 8 | First byte of the host command |
| fifo_full | input | 1 | Bridge FIFO cannot take a byte (1 = full) |
| fifo_empty | input | 1 | Bridge FIFO holds no data (1 = empty) |
| buf_valid | input | 1 | Capture buffer has a byte on `buf_byte` |
| buf_byte | input | DATA_W | Next byte from the capture buffer |
| buf_overflow | input | 1 | Capture buffer lost data |
| fifo_addr | output | 2 | Bridge FIFO select |
| fifo_wr_n | output | 1 | Active-low write strobe to the bridge |
| fifo_data | output | DATA_W | Data bus to the bridge |
| buf_rd | output | 1 | Pops `buf_byte` at the next edge |
| cap_start | output | 1 | One-cycle start command to the capture buffer |
| ovf_flag | output | 1 | Sticky overflow-abort status |

## Verification
The bound checker watches the bridge-side timing rules on every cycle. It checks that no strobe follows a full edge, that each strobe lasts one cycle with data held from the cycle before, and that the select value is right during strobes. It also checks that the start pulse is one cycle wide, that no pop happens without valid data, and that the overflow flag rises only after an overflow report. Other behaviour depends on sequences of states and can only be shown by the bench scenarios. These are the exact boundary of the timeout and the timer restart, gating on the empty flag, dropping of commands outside the wait state, the two-cycle byte rate, and ordered byte delivery across acquisitions.

// File: rtl/upl_pkg.sv
package upl_pkg;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_WAIT_CMD,
        ST_CMD_PRO,
        ST_UPLOAD
    } upl_state_e;

    typedef enum logic [1:0] {
        PH_EMPTY,
        PH_LOADED,
        PH_STROBE
    } wr_phase_e;

endpackage

// File: rtl/upl_cmd_match.sv
module upl_cmd_match #(
    parameter int               CMD_W      = 8,
    parameter logic [CMD_W-1:0] START_CODE = 8'h0a
) (
    input  logic             armed,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_byte,
    output logic             start_hit
);
    // Only the first command byte is decoded; the match counts only while armed.
    always_comb begin
        start_hit = armed && cmd_valid && (cmd_byte == START_CODE);
    end
endmodule

// File: rtl/upl_stall_timer.sv
module upl_stall_timer #(
    parameter int TIMEOUT_CYC = 72000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int              CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Counts consecutive full edges; any edge without run clears it.
    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
        expired = run && (cnt_q == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/upl_wr_engine.sv
module upl_wr_engine
    import upl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fifo_full,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_byte,
    output logic              src_pop,
    output logic              wr_n,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        wr_phase_e         phase;
        logic              wr_n;
        logic [DATA_W-1:0] data;
    } eng_t;

    eng_t eng_d, eng_q;

    // EMPTY -> LOADED (data on bus) -> STROBE (wr_n low) -> LOADED ...
    // A pop in the strobe cycle changes the bus only after the strobe ends.
    always_comb begin
        eng_d      = eng_q;
        eng_d.wr_n = 1'b1;
        src_pop    = 1'b0;
        if (!enable) begin
            eng_d.phase = PH_EMPTY;
        end else begin
            unique case (eng_q.phase)
                PH_EMPTY: begin
                    if (src_valid) begin
                        src_pop     = 1'b1;
                        eng_d.data  = src_byte;
                        eng_d.phase = PH_LOADED;
                    end
                end
                PH_LOADED: begin
                    if (!fifo_full) begin
                        eng_d.wr_n  = 1'b0;
                        eng_d.phase = PH_STROBE;
                    end
                end
                PH_STROBE: begin
                    if (src_valid) begin
                        src_pop     = 1'b1;
                        eng_d.data  = src_byte;
                        eng_d.phase = PH_LOADED;
                    end else begin
                        eng_d.phase = PH_EMPTY;
                    end
                end
                default: eng_d.phase = PH_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{phase: PH_EMPTY, wr_n: 1'b1, data: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign wr_n = eng_q.wr_n;
    assign data = eng_q.data;
endmodule

// File: rtl/upl_ctrl.sv
module upl_ctrl
    import upl_pkg::*;
#(
    parameter int               DATA_W      = 8,
    parameter logic [7:0]       START_CODE  = 8'h0a,
    parameter logic [1:0]       FIFO_ADDR   = 2'b10,
    parameter int               TIMEOUT_CYC = 72000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic              buf_valid,
    input  logic [DATA_W-1:0] buf_byte,
    input  logic              buf_overflow,
    output logic [1:0]        fifo_addr,
    output logic              fifo_wr_n,
    output logic [DATA_W-1:0] fifo_data,
    output logic              buf_rd,
    output logic              cap_start,
    output logic              ovf_flag
);
    typedef struct packed {
        upl_state_e state;
        logic [1:0] addr;
        logic       cap_start;
        logic       ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic start_hit;
    logic stall_run;
    logic stall_expired;
    logic abort_now;
    logic eng_enable;

    upl_cmd_match #(
        .CMD_W      (8),
        .START_CODE (START_CODE)
    ) u_match (
        .armed     (ctl_q.state == ST_WAIT_CMD),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .start_hit (start_hit)
    );

    assign stall_run  = (ctl_q.state == ST_UPLOAD) && fifo_full;
    assign abort_now  = (ctl_q.state == ST_UPLOAD) && (buf_overflow || stall_expired);
    assign eng_enable = (ctl_q.state == ST_UPLOAD) && !abort_now;

    upl_stall_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (stall_run),
        .expired (stall_expired)
    );

    upl_wr_engine #(
        .DATA_W (DATA_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (eng_enable),
        .fifo_full (fifo_full),
        .src_valid (buf_valid),
        .src_byte  (buf_byte),
        .src_pop   (buf_rd),
        .wr_n      (fifo_wr_n),
        .data      (fifo_data)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.cap_start = 1'b0;
        unique case (ctl_q.state)
            ST_INIT: begin
                ctl_d.addr  = FIFO_ADDR;
                ctl_d.state = ST_WAIT_CMD;
            end
            ST_WAIT_CMD: begin
                if (start_hit) begin
                    ctl_d.state     = ST_CMD_PRO;
                    ctl_d.cap_start = 1'b1;
                    ctl_d.ovf       = 1'b0;
                end
            end
            ST_CMD_PRO: begin
                if (fifo_empty) begin
                    ctl_d.state = ST_UPLOAD;
                end
            end
            ST_UPLOAD: begin
                if (buf_overflow) begin
                    ctl_d.ovf   = 1'b1;
                    ctl_d.state = ST_WAIT_CMD;
                end else if (stall_expired) begin
                    ctl_d.state = ST_WAIT_CMD;
                end
            end
            default: ctl_d.state = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_INIT, addr: 2'b00, cap_start: 1'b0, ovf: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign fifo_addr = ctl_q.addr;
    assign cap_start = ctl_q.cap_start;
    assign ovf_flag  = ctl_q.ovf;
endmodule

module upl_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_full,
    input logic              buf_valid,
    input logic              buf_overflow,
    input logic [1:0]        fifo_addr,
    input logic              fifo_wr_n,
    input logic [DATA_W-1:0] fifo_data,
    input logic              buf_rd,
    input logic              cap_start,
    input logic              ovf_flag
);
    p_strobe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_wr_n) |-> !$past(fifo_full));

    p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_wr_n |=> fifo_wr_n);

    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_wr_n) |-> $stable(fifo_data));

    p_pop_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |-> buf_valid);

    p_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_wr_n |-> (fifo_addr == 2'b10));

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_start |=> !cap_start);

    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(buf_overflow));
endmodule

bind upl_ctrl upl_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_full    (fifo_full),
    .buf_valid    (buf_valid),
    .buf_overflow (buf_overflow),
    .fifo_addr    (fifo_addr),
    .fifo_wr_n    (fifo_wr_n),
    .fifo_data    (fifo_data),
    .buf_rd       (buf_rd),
    .cap_start    (cap_start),
    .ovf_flag     (ovf_flag)
);

// File: tb/upl_ctrl_test.sv
`timescale 1ns/1ps
module upl_ctrl_test;
    localparam int         TMO  = 16;
    localparam logic [7:0] SEED = 8'hA0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       fifo_full = 1'b0;
    logic       fifo_empty = 1'b0;
    logic       buf_valid = 1'b0;
    logic [7:0] src_val = 8'h00;
    logic       buf_overflow = 1'b0;
    logic [1:0] fifo_addr;
    logic       fifo_wr_n;
    logic [7:0] fifo_data;
    logic       buf_rd;
    logic       cap_start;
    logic       ovf_flag;

    int checks = 0;
    int failures = 0;
    int cap_cnt = 0;
    int strobe_cnt = 0;
    int pop_cnt = 0;
    bit done = 0;

    logic [7:0] exp_byte = SEED;
    logic       full_prev = 1'b0;
    logic       wr_prev = 1'b1;
    logic [7:0] data_prev = 8'h00;

    upl_ctrl #(.DATA_W(8), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .buf_valid(buf_valid),
        .buf_byte(src_val), .buf_overflow(buf_overflow), .fifo_addr(fifo_addr),
        .fifo_wr_n(fifo_wr_n), .fifo_data(fifo_data), .buf_rd(buf_rd),
        .cap_start(cap_start), .ovf_flag(ovf_flag)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_cmd(input logic [7:0] b);
        cmd_byte  = b;
        cmd_valid = 1'b1;
        tick(1);
        cmd_valid = 1'b0;
    endtask

    // Capture buffer model: restarts at SEED on each start, advances on pop.
    always @(posedge clk) begin
        if (cap_start)   src_val <= SEED;
        else if (buf_rd) src_val <= src_val + 8'd1;
    end

    // Bridge-side monitor.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cap_start) cap_cnt++;
            if (buf_rd) pop_cnt++;
            if (!fifo_wr_n) begin
                strobe_cnt++;
                chk(full_prev == 1'b0, "R4 strobe after full edge", int'(full_prev), 0);
                chk(wr_prev == 1'b1, "R4 strobe wider than one cycle", int'(wr_prev), 1);
                chk(fifo_data == exp_byte, "R5 byte order", int'(fifo_data), int'(exp_byte));
                chk(fifo_data == data_prev, "R5 data not held before strobe", int'(fifo_data), int'(data_prev));
                chk(fifo_addr == 2'b10, "R1 address during strobe", int'(fifo_addr), 2);
                exp_byte = exp_byte + 8'd1;
            end
            if (cap_start) exp_byte = SEED;
        end
        full_prev = fifo_full;
        wr_prev   = fifo_wr_n;
        data_prev = fifo_data;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s;
        int p;
        // R1: reset values
        tick(3);
        chk(fifo_wr_n == 1'b1, "R1 wr_n in reset", int'(fifo_wr_n), 1);
        chk(fifo_addr == 2'b00, "R1 addr in reset", int'(fifo_addr), 0);
        chk(fifo_data == 8'h00, "R1 data in reset", int'(fifo_data), 0);
        chk(!cap_start && !buf_rd && !ovf_flag, "R1 controls in reset",
            int'({cap_start, buf_rd, ovf_flag}), 0);
        rst_n = 1'b1;
        tick(3);
        chk(fifo_addr == 2'b10, "R1 addr after init", int'(fifo_addr), 2);

        // R2: every byte other than the start code is ignored
        for (int b = 0; b < 256; b++) begin
            if (b != 8'h0a) begin
                send_cmd(8'(b));
                tick(2);
            end
        end
        chk(cap_cnt == 0, "R2 non-start byte sweep", cap_cnt, 0);
        cmd_byte = 8'h0a;
        tick(5);
        chk(cap_cnt == 0, "R2 start code without valid", cap_cnt, 0);

        // R3: upload held off until the bridge reports empty
        buf_valid  = 1'b1;
        fifo_empty = 1'b0;
        send_cmd(8'h0a);
        tick(2);
        chk(cap_cnt == 1, "R2 start code accepted", cap_cnt, 1);
        tick(30);
        chk(strobe_cnt == 0, "R3 no strobe before empty", strobe_cnt, 0);
        chk(pop_cnt == 0, "R3 no pop before empty", pop_cnt, 0);
        fifo_empty = 1'b1;
        tick(10);
        chk(strobe_cnt > 0, "R3 upload after empty", strobe_cnt, 1);

        // R6: two cycles per byte
        s = strobe_cnt;
        tick(40);
        chk(strobe_cnt - s == 20, "R6 byte rate", strobe_cnt - s, 20);

        // R2: command during upload ignored
        send_cmd(8'h0a);
        tick(2);
        chk(cap_cnt == 1, "R2 command while busy", cap_cnt, 1);

        // R4/R5: sweep every 4-cycle full pattern
        for (int pat = 0; pat < 16; pat++) begin
            s = strobe_cnt;
            for (int k = 0; k < 12; k++) begin
                fifo_full = pat[k % 4];
                tick(1);
            end
            if (pat == 15) chk(strobe_cnt - s <= 1, "R4 all-full pattern", strobe_cnt - s, 0);
            else           chk(strobe_cnt - s > 0, "R4 pattern progress", strobe_cnt - s, 1);
        end
        fifo_full = 1'b0;
        tick(4);

        // R9 and R7 lower bound: two sub-threshold runs split by one clear edge
        fifo_full = 1'b1;
        tick(TMO - 1);
        fifo_full = 1'b0;
        tick(1);
        fifo_full = 1'b1;
        tick(TMO - 1);
        fifo_full = 1'b0;
        s = strobe_cnt;
        tick(10);
        chk(strobe_cnt > s, "R9 timer restart keeps upload", strobe_cnt - s, 1);
        chk(strobe_cnt > s, "R7 below threshold keeps upload", strobe_cnt - s, 1);

        // R7: full for exactly TMO edges ends the upload
        fifo_full = 1'b1;
        tick(TMO);
        fifo_full = 1'b0;
        s = strobe_cnt;
        p = pop_cnt;
        tick(20);
        chk(strobe_cnt == s, "R7 no strobe after timeout", strobe_cnt - s, 0);
        chk(pop_cnt == p, "R7 no pop after timeout", pop_cnt - p, 0);
        send_cmd(8'h0a);
        tick(2);
        chk(cap_cnt == 2, "R7 back in command wait", cap_cnt, 2);
        tick(10);
        chk(ovf_flag == 1'b0, "R8 flag clear initially", int'(ovf_flag), 0);

        // R8: overflow abort
        buf_overflow = 1'b1;
        tick(1);
        buf_overflow = 1'b0;
        chk(ovf_flag == 1'b1, "R8 flag set", int'(ovf_flag), 1);
        s = strobe_cnt;
        tick(20);
        chk(strobe_cnt == s, "R8 upload stopped", strobe_cnt - s, 0);
        chk(ovf_flag == 1'b1, "R8 flag sticky", int'(ovf_flag), 1);
        fifo_empty = 1'b0;
        send_cmd(8'h0a);
        tick(1);
        chk(ovf_flag == 1'b0, "R8 flag cleared by start", int'(ovf_flag), 0);
        buf_overflow = 1'b1;
        tick(1);
        buf_overflow = 1'b0;
        chk(ovf_flag == 1'b0, "R8 overflow ignored outside upload", int'(ovf_flag), 0);
        fifo_empty = 1'b1;
        s = strobe_cnt;
        tick(10);
        chk(strobe_cnt > s, "R8 upload not aborted", strobe_cnt - s, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule